// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves as a cascadable 2K x 8 serial EEPROM. It oversamples SCL and SDA on the system clock. It detects START, STOP and SCL edges, and it pulls SDA low through an open-drain enable. Three strap inputs give the device its select code. The upper three bits of the 11-bit array address travel in the device byte. A second byte carries the lower eight bits.

Write data is staged in a 16-byte page buffer and is not written to the array when it arrives. A STOP commits the buffer. The device then enters a busy window of a configurable number of system clocks, during which it refuses every address. A master can poll for completion by repeating START plus a write address until it sees an ACK. A write-protect input makes the array read-only. Reads stream bytes from an auto-incrementing pointer for as long as the master acknowledges.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The device byte is {1, S2..S0, B2..B0, RW}, sent MSB first. The target acknowledges it only when bit 7 is 1, bits 6:4 equal `sel_i` and no programming window is running. Otherwise the target stays silent until the next START.
- R2: In a write (RW=0), the byte after the device byte loads the pointer with {B2..B0, byte} and is acknowledged.
- R3: Each data byte is acknowledged and staged at the pointer's page offset. Afterwards the low 4 pointer bits increment modulo 16 and the upper 7 bits stay fixed. A 17th or later byte overwrites the earlier byte at the same offset.
- R4: The array does not change before STOP. On STOP, every staged byte is written into its page. Offsets of that page that received no byte keep their contents, and other pages are not touched.
- R5: A STOP that follows at least one staged byte starts a busy window of PROG_CYCLES system clocks, with a minimum of 16. During the window the target acknowledges nothing, including its own device byte. It acknowledges again once the window ends.
- R6: With `wp_i` high, the device byte and address byte are still acknowledged. The first data byte is refused, no busy window follows, and the array keeps its contents.
- R7: A device byte with RW=1 replaces the pointer's upper three bits with B2..B0. The target then sends the byte at the pointer MSB first, and the pointer advances by one per byte over the whole 11-bit space, wrapping from 0x7FF to 0x000. A read with no address byte continues from the pointer.
- R8: A master ACK (SDA low in the ninth clock) makes the target send the next byte. A NACK makes it release SDA and ignore further clocks until START or STOP.
- R9: A START or repeated START at any point returns the target to device-byte reception and discards staged bytes that have not yet been committed. A later STOP then commits nothing. The pointer is kept, which makes a random read possible.
- R10: SDA is sampled on rising SCL. `sda_oe_o` changes only while SCL is low.
- R11: After reset, SDA is released and every array byte reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wp_i | input | 1 | Write protect: 1 makes the array read-only |
| sel_i | input | 3 | Strapped device select code |

## Verification
The hardest state to reach from the pins is an overflowing page write whose commit overlaps a master that polls at once. The bench sends 18 data bytes that start four bytes before the end of a page, so the pointer wraps and overwrites two early offsets. It issues STOP and immediately polls with a write address, which must be refused, then waits past the programming window and polls again. It then reads the page back across the page boundary and compares every offset against a model that tracks which offsets were overwritten and which were never written.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int unsigned ADDR_W = 11;
  localparam int unsigned BLK_W  = 3;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_MACK
  } st_e;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_o;
      sda_q  <= sda_o;
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // data transitions while the clock is held high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic [PAGE_W-1:0] ridx_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              any_o
);
  localparam int unsigned DEPTH = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
    end else if (we_i) begin
      slot_q[widx_i] <= wdata_i;
      vld_q[widx_i]  <= 1'b1;
    end
  end

  assign rdata_o  = slot_q[ridx_i];
  assign rvalid_o = vld_q[ridx_i];
  assign any_o    = |vld_q;

  AST_NO_STAGE_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && clr_i)); // R9
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eep_prog_seq.sv
module eep_prog_seq #(
  parameter int unsigned PROG_CYCLES = 5000,
  parameter int unsigned PAGE_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              step_o,
  output logic [PAGE_W-1:0] idx_o,
  output logic              done_o
);
  localparam int unsigned DEPTH = 1 << PAGE_W;
  localparam int unsigned CYC   = (PROG_CYCLES < DEPTH) ? DEPTH : PROG_CYCLES;
  localparam int unsigned CNT_W = $clog2(CYC + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              run_q;
  logic [PAGE_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      idx_q <= '0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(CYC);
      run_q <= 1'b1;
      idx_q <= '0;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (run_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == PAGE_W'(DEPTH - 1)) run_q <= 1'b0;
      end
    end
  end

  assign busy_o = (cnt_q != '0);
  assign step_o = run_q;
  assign idx_o  = idx_q;
  assign done_o = run_q && (idx_q == PAGE_W'(DEPTH - 1));

  AST_COMMIT_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> busy_o); // R5
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R5
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eep_pkg::*;
#(
  parameter int unsigned PAGE_W      = 4,
  parameter int unsigned PROG_CYCLES = 5000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             wp_i,
  input  logic [SEL_W-1:0] sel_i
);
  localparam int unsigned PG_W = ADDR_W - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  st_e               st_q, ack_nxt_q;
  logic [2:0]        cnt_q;
  logic              got_q;
  logic [DATA_W-1:0] sh_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [BLK_W-1:0]  blk_q;
  logic              oe_q;
  logic              mack_q;
  logic [PG_W-1:0]   page_q;

  logic              busy, step, done;
  logic [PAGE_W-1:0] cidx;
  logic [DATA_W-1:0] buf_rdata, mem_rdata;
  logic              buf_rvalid, buf_any;
  logic              buf_we, buf_clr, prog_start, dev_hit, mem_we;

  always_comb begin
    dev_hit    = sh_q[7] && (sh_q[6:4] == sel_i) && !busy;
    buf_we     = scl_fall && got_q && (st_q == ST_WDATA) && !wp_i;
    buf_clr    = (start_det && !busy) || done;
    prog_start = stop_det && buf_any && !busy;
    mem_we     = step && buf_rvalid;
  end

  eep_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (buf_we),
    .widx_i   (ptr_q[PAGE_W-1:0]),
    .wdata_i  (sh_q),
    .clr_i    (buf_clr),
    .ridx_i   (cidx),
    .rdata_o  (buf_rdata),
    .rvalid_o (buf_rvalid),
    .any_o    (buf_any)
  );

  eep_prog_seq #(.PROG_CYCLES(PROG_CYCLES), .PAGE_W(PAGE_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prog_start),
    .busy_o  (busy),
    .step_o  (step),
    .idx_o   (cidx),
    .done_o  (done)
  );

  eep_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i ({page_q, cidx}),
    .wdata_i (buf_rdata),
    .raddr_i (ptr_q),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ack_nxt_q <= ST_IDLE;
      cnt_q     <= '0;
      got_q     <= 1'b0;
      sh_q      <= '0;
      ptr_q     <= '0;
      blk_q     <= '0;
      oe_q      <= 1'b0;
      mack_q    <= 1'b0;
      page_q    <= '0;
    end else begin
      if (prog_start) page_q <= ptr_q[ADDR_W-1:PAGE_W];
      if (start_det) begin
        st_q  <= ST_DEV;
        cnt_q <= '0;
        got_q <= 1'b0;
        oe_q  <= 1'b0;
      end else if (stop_det) begin
        st_q  <= ST_IDLE;
        got_q <= 1'b0;
        oe_q  <= 1'b0;
      end else begin
        unique case (st_q)
          ST_DEV, ST_ADDR, ST_WDATA: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[DATA_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
              got_q <= (cnt_q == 3'd7);
            end else if (scl_fall && got_q) begin
              got_q <= 1'b0;
              if (st_q == ST_DEV) begin
                if (!dev_hit) begin
                  st_q <= ST_IDLE;
                end else begin
                  oe_q  <= 1'b1;
                  st_q  <= ST_ACK;
                  blk_q <= sh_q[3:1];
                  if (sh_q[0]) begin
                    ptr_q[ADDR_W-1:ADDR_W-BLK_W] <= sh_q[3:1];
                    ack_nxt_q <= ST_TX;
                  end else begin
                    ack_nxt_q <= ST_ADDR;
                  end
                end
              end else if (st_q == ST_ADDR) begin
                ptr_q     <= {blk_q, sh_q};
                oe_q      <= 1'b1;
                st_q      <= ST_ACK;
                ack_nxt_q <= ST_WDATA;
              end else begin
                if (wp_i) begin
                  st_q <= ST_IDLE;
                end else begin
                  ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;
                  oe_q      <= 1'b1;
                  st_q      <= ST_ACK;
                  ack_nxt_q <= ST_WDATA;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (ack_nxt_q == ST_TX) begin
                sh_q  <= mem_rdata;
                oe_q  <= ~mem_rdata[DATA_W-1];
                ptr_q <= ptr_q + 1'b1;
                st_q  <= ST_TX;
              end else begin
                oe_q <= 1'b0;
                st_q <= ack_nxt_q;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt_q == 3'd7) begin
                oe_q  <= 1'b0;
                cnt_q <= '0;
                st_q  <= ST_MACK;
              end else begin
                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                oe_q  <= ~sh_q[DATA_W-2];
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                sh_q  <= mem_rdata;
                oe_q  <= ~mem_rdata[DATA_W-1];
                ptr_q <= ptr_q + 1'b1;
                cnt_q <= '0;
                st_q  <= ST_TX;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;

  AST_QUIET_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o); // R5
  AST_SDA_LOW_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(!scl_s || start_det || stop_det)); // R10
  AST_PAGE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we |=> $stable(ptr_q[ADDR_W-1:PAGE_W])); // R3
  AST_MEM_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> busy); // R4
endmodule

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;
  localparam int PROG = 2000;
  localparam int Q    = 8;
  localparam int H    = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_drv = 1'b1;
  logic       wp = 1'b0;
  logic [2:0] sel = 3'b101;
  logic       sda_oe;
  logic       sda_bus;

  assign sda_bus = sda_drv & ~sda_oe;

  i2c_eeprom_target #(.PAGE_W(4), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .wp_i     (wp),
    .sel_i    (sel)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int    exp_q[$];
  int    act_q[$];
  string tag_q[$];
  logic [7:0] model [0:2047];

  // scoreboard monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      int e, a;
      string t;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (e != a) begin
        n_fail++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
      end
    end
  end

  // R10: SDA drive changes only while SCL is low
  always @(sda_oe) begin
    if (rst_n) begin
      n_checks++;
      if (scl !== 1'b0) begin
        n_fail++;
        $display("FAIL R10: actual scl=%0b expected 0 at sda_oe change", scl);
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_v(input string t, input int e);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wclk(Q);
    scl = 1'b1;     wclk(Q);
    sda_drv = 1'b0; wclk(Q);
    scl = 1'b0;     wclk(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wclk(Q);
    scl = 1'b1;     wclk(Q);
    sda_drv = 1'b1; wclk(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_drv = b; wclk(Q);
    scl = 1'b1;  wclk(H);
    scl = 1'b0;  wclk(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_drv = 1'b1; wclk(Q);
    scl = 1'b1;     wclk(H / 2);
    b = sda_bus;    wclk(H / 2);
    scl = 1'b0;     wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int exp_ack, input string t);
    logic a;
    expect_v(t, exp_ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    act_q.push_back(a ? 0 : 1);
  endtask

  task automatic recv_byte(input logic mack, input logic [7:0] e, input string t);
    logic [7:0] d;
    logic bt;
    expect_v(t, int'(e));
    for (int i = 7; i >= 0; i--) begin
      get_bit(bt);
      d[i] = bt;
    end
    put_bit(mack ? 1'b0 : 1'b1);
    act_q.push_back(int'(d));
  endtask

  function automatic logic [7:0] dbyte(input logic [2:0] blk, input logic rw);
    return {1'b1, sel, blk, rw};
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual run still active, expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2048; i++) model[i] = 8'h00;
    wclk(5);
    expect_v("R11 sda released in reset", 0);
    act_q.push_back(int'(sda_oe));
    rst_n = 1'b1;
    wclk(5);

    // R1: select mismatch and missing fixed bit
    bus_start();
    send_byte({1'b1, 3'b010, 3'b000, 1'b0}, 0, "R1 select mismatch");
    bus_stop();
    bus_start();
    send_byte({1'b0, sel, 3'b000, 1'b0}, 0, "R1 bit7 clear");
    bus_stop();

    // R9: repeated START discards staged data; random read sees old content
    bus_start();
    send_byte(dbyte(3'd0, 1'b0), 1, "R1 device ack");
    send_byte(8'h50, 1, "R2 address ack");
    send_byte(8'hA5, 1, "R3 data ack");
    send_byte(8'h5A, 1, "R3 data ack");
    bus_start();
    send_byte(dbyte(3'd0, 1'b0), 1, "R9 ack after abort");
    send_byte(8'h50, 1, "R2 address ack");
    bus_start();
    send_byte(dbyte(3'd0, 1'b1), 1, "R7 read device ack");
    recv_byte(1'b0, 8'h00, "R9 aborted data not written");
    bus_stop();
    bus_start();
    send_byte(dbyte(3'd0, 1'b0), 1, "R9 no busy after aborted write");
    bus_stop();

    // R3/R4/R5: overflowing page write, busy poll, readback across page end
    bus_start();
    send_byte(dbyte(3'd1, 1'b0), 1, "R1 device ack");
    send_byte(8'hFC, 1, "R2 address ack");
    for (int k = 0; k < 18; k++) begin
      logic [7:0] d;
      d = 8'h10 + 8'(k);
      send_byte(d, 1, "R3 page data ack");
      model[{3'd1, 4'hF, 4'((12 + k) % 16)}] = d;
    end
    bus_stop();
    bus_start();
    send_byte(dbyte(3'd1, 1'b0), 0, "R5 no ack while busy");
    bus_stop();
    wclk(PROG);
    bus_start();
    send_byte(dbyte(3'd1, 1'b0), 1, "R5 ack after window");
    send_byte(8'hF0, 1, "R2 address ack");
    bus_start();
    send_byte(dbyte(3'd1, 1'b1), 1, "R7 read device ack");
    for (int a = 16'h1F0; a <= 16'h200; a++)
      recv_byte(a != 16'h200, model[a], "R4 page readback");
    bus_stop();

    // R7: pointer wrap over the whole space
    bus_start();
    send_byte(dbyte(3'd0, 1'b0), 1, "R1 device ack");
    send_byte(8'h00, 1, "R2 address ack");
    send_byte(8'h81, 1, "R3 data ack");
    send_byte(8'h42, 1, "R3 data ack");
    bus_stop();
    model[0] = 8'h81;
    model[1] = 8'h42;
    wclk(PROG + 50);
    bus_start();
    send_byte(dbyte(3'd7, 1'b0), 1, "R1 device ack");
    send_byte(8'hFF, 1, "R2 address ack");
    send_byte(8'h3C, 1, "R3 data ack");
    bus_stop();
    model[11'h7FF] = 8'h3C;
    wclk(PROG + 50);
    bus_start();
    send_byte(dbyte(3'd7, 1'b0), 1, "R1 device ack");
    send_byte(8'hFE, 1, "R2 address ack");
    bus_start();
    send_byte(dbyte(3'd7, 1'b1), 1, "R7 read device ack");
    recv_byte(1'b1, model[11'h7FE], "R7 read 0x7FE");
    recv_byte(1'b1, model[11'h7FF], "R7 read 0x7FF");
    recv_byte(1'b0, model[0], "R7 wrap to 0x000");
    bus_stop();

    // R7 current address read, R8 release after NACK
    bus_start();
    send_byte(dbyte(3'd0, 1'b1), 1, "R7 read device ack");
    recv_byte(1'b0, model[1], "R7 current address read");
    recv_byte(1'b0, 8'hFF, "R8 SDA released after nack");
    bus_stop();

    // R6: write protect
    bus_start();
    send_byte(dbyte(3'd3, 1'b0), 1, "R1 device ack");
    send_byte(8'h10, 1, "R2 address ack");
    send_byte(8'h77, 1, "R3 data ack");
    bus_stop();
    model[11'h310] = 8'h77;
    wclk(PROG + 50);
    wp = 1'b1;
    bus_start();
    send_byte(dbyte(3'd3, 1'b0), 1, "R6 device ack under protect");
    send_byte(8'h10, 1, "R6 address ack under protect");
    send_byte(8'h99, 0, "R6 first data refused");
    bus_stop();
    wp = 1'b0;
    bus_start();
    send_byte(dbyte(3'd3, 1'b0), 1, "R6 no busy window");
    send_byte(8'h10, 1, "R2 address ack");
    bus_start();
    send_byte(dbyte(3'd3, 1'b1), 1, "R7 read device ack");
    recv_byte(1'b0, model[11'h310], "R6 protected byte unchanged");
    bus_stop();

    wait (act_q.size() == 0);
    wclk(4);
    finish_run();
  end
endmodule